// File: doc/BRIEF.md
# External Sync Presence Detector

This block judges whether an external horizontal sync source is present. Once per horizontal line it receives a strobe and a flag saying whether a sync pulse was seen during that line. It counts unbroken runs of lines: runs of hits while the source is judged absent, and runs of misses while it is judged present. When a run reaches the programmed length, the one-bit presence flag changes state. The flag can then steer a display timing generator between following external sync and running from its own internal timing.

Acquisition and loss use separate thresholds, so the hysteresis is asymmetric. A short burst of hits is enough to lock on. Losing the source takes a much longer run of misses, and loss can be disabled altogether. Both threshold fields are one-hot codes. A code with several bits set is read as the largest length its field offers.

Top module: `sync_presence_detector`

## Requirements
- R1: While rstN is low and after it is released, syncPresent is 0 and the run count is empty.
- R2: With acqCode = 3'b000, the first strobed line with syncHit = 1 sets syncPresent.
- R3: acqCode values 3'b001, 3'b010 and 3'b100 require 4, 8 and 16 consecutive strobed hit lines. syncPresent rises on the line that completes the run and stays low before that line.
- R4: While syncPresent is 0, a strobed line with syncHit = 0 empties the hit run, so counting starts again from zero.
- R5: lossCode values 4'b0001, 4'b0010, 4'b0100 and 4'b1000 require 32, 64, 128 and 256 consecutive strobed miss lines. syncPresent falls on the line that completes the run.
- R6: With lossCode = 4'b0000, syncPresent never falls once it is set, however many miss lines arrive.
- R7: While syncPresent is 1, a strobed line with syncHit = 1 empties the miss run.
- R8: A code with more than one bit set behaves as the largest length of its field: 16 hits for acqCode and 256 misses for lossCode.
- R9: In a cycle where lineStrobe is 0, syncHit is ignored. Neither syncPresent nor the run count changes.
- R10: syncPresent is registered. It changes at the clock edge that samples the strobe of the line completing a run. A run counts as complete when its length reaches or passes the threshold in force on that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lineStrobe | input | 1 | One-cycle pulse, once per horizontal line |
| syncHit | input | 1 | Sync seen on this line; read only while lineStrobe is 1 |
| acqCode | input | 3 | Acquire run length code (one-hot) |
| lossCode | input | 4 | Loss run length code (one-hot, 0 = never) |
| syncPresent | output | 1 | 1 while external sync is judged present |

## Verification
The hardest cases to reach are the longest loss runs: 256 unbroken misses, or an unbroken run that is broken by a single hit on its last line. Uniform random stimulus almost never produces either. The stimulus therefore runs in bursts in which the hit probability is held very high or very low for hundreds of lines. It also includes directed sequences that stop one line short of each threshold, and sequences that insert a stray hit or miss just before the run completes. Codes with several bits set are used both in the directed sequences and in the random mix.

// File: rtl/spd_pkg.sv
package spd_pkg;
  // Strobes from the control to the run counter
  typedef struct packed {
    logic runInc;
    logic runClr;
  } runCtl_t;
endpackage

// File: rtl/spd_thr_decode.sv
module spd_thr_decode #(
  parameter int CODE_W = 3,
  parameter int UNIT   = 4,
  parameter int CNT_W  = 9
) (
  input  logic [CODE_W-1:0] code,
  output logic [CNT_W-1:0]  thr,
  output logic              isZero
);
  localparam logic [CNT_W-1:0] UNIT_V = CNT_W'(UNIT);

  always_comb begin
    thr    = '0;
    isZero = (code == '0);
    if ($countones(code) > 1) begin
      thr = UNIT_V << (CODE_W - 1);
    end else begin
      for (int i = 0; i < CODE_W; i++) begin
        if (code[i]) thr = UNIT_V << i;
      end
    end
  end
endmodule

// File: rtl/spd_datapath.sv
module spd_datapath
  import spd_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  runCtl_t          ctl,
  input  logic [CNT_W-1:0] acqThr,
  input  logic [CNT_W-1:0] lossThr,
  output logic [CNT_W-1:0] runCnt,
  output logic             acqReached,
  output logic             lossReached
);
  logic [CNT_W-1:0] nextCnt;

  always_comb begin
    nextCnt = (&runCnt) ? runCnt : runCnt + 1'b1;
    acqReached  = (nextCnt >= acqThr);
    lossReached = (nextCnt >= lossThr);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           runCnt <= '0;
    else if (ctl.runClr) runCnt <= '0;
    else if (ctl.runInc) runCnt <= nextCnt;
  end
endmodule

// File: rtl/spd_control.sv
module spd_control
  import spd_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    lineStrobe,
  input  logic    syncHit,
  input  logic    acqReached,
  input  logic    lossReached,
  input  logic    lossNever,
  output runCtl_t ctl,
  output logic    present
);
  logic presentNext;

  always_comb begin
    ctl         = '0;
    presentNext = present;
    if (lineStrobe) begin
      if (!present) begin
        if (syncHit) begin
          if (acqReached) begin
            presentNext = 1'b1;
            ctl.runClr  = 1'b1;
          end else begin
            ctl.runInc  = 1'b1;
          end
        end else begin
          ctl.runClr = 1'b1;
        end
      end else begin
        if (!syncHit && !lossNever) begin
          if (lossReached) begin
            presentNext = 1'b0;
            ctl.runClr  = 1'b1;
          end else begin
            ctl.runInc  = 1'b1;
          end
        end else begin
          ctl.runClr = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) present <= 1'b0;
    else       present <= presentNext;
  end
endmodule

// File: rtl/sync_presence_detector.sv
module sync_presence_detector
  import spd_pkg::*;
#(
  parameter int ACQ_W     = 3,
  parameter int LOSS_W    = 4,
  parameter int ACQ_UNIT  = 4,
  parameter int LOSS_UNIT = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineStrobe,
  input  logic              syncHit,
  input  logic [ACQ_W-1:0]  acqCode,
  input  logic [LOSS_W-1:0] lossCode,
  output logic              syncPresent
);
  localparam int ACQ_MAX  = ACQ_UNIT  << (ACQ_W - 1);
  localparam int LOSS_MAX = LOSS_UNIT << (LOSS_W - 1);
  localparam int THR_MAX  = (ACQ_MAX > LOSS_MAX) ? ACQ_MAX : LOSS_MAX;
  localparam int CNT_W    = $clog2(THR_MAX + 1);

  runCtl_t          ctl;
  logic [CNT_W-1:0] acqThr, lossThr, runCnt;
  logic             acqZero, lossNever, acqReached, lossReached;

  spd_thr_decode #(.CODE_W(ACQ_W), .UNIT(ACQ_UNIT), .CNT_W(CNT_W)) acqDec_i (
    .code(acqCode), .thr(acqThr), .isZero(acqZero));

  spd_thr_decode #(.CODE_W(LOSS_W), .UNIT(LOSS_UNIT), .CNT_W(CNT_W)) lossDec_i (
    .code(lossCode), .thr(lossThr), .isZero(lossNever));

  spd_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .acqThr(acqThr), .lossThr(lossThr),
    .runCnt(runCnt), .acqReached(acqReached), .lossReached(lossReached));

  spd_control ctrl_i (
    .clk(clk), .rstN(rstN), .lineStrobe(lineStrobe), .syncHit(syncHit),
    .acqReached(acqReached), .lossReached(lossReached), .lossNever(lossNever),
    .ctl(ctl), .present(syncPresent));
endmodule

// File: rtl/spd_checker.sv
module spd_checker #(
  parameter int ACQ_W  = 3,
  parameter int LOSS_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              lineStrobe,
  input logic              syncHit,
  input logic [ACQ_W-1:0]  acqCode,
  input logic [LOSS_W-1:0] lossCode,
  input logic              syncPresent
);
  assert_idle_line_R9: assert property (@(posedge clk) disable iff (!rstN)
    !lineStrobe |=> $stable(syncPresent));

  assert_miss_keeps_absent_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!syncPresent && lineStrobe && !syncHit) |=> !syncPresent);

  assert_hit_keeps_present_R7: assert property (@(posedge clk) disable iff (!rstN)
    (syncPresent && lineStrobe && syncHit) |=> syncPresent);

  assert_never_lose_R6: assert property (@(posedge clk) disable iff (!rstN)
    (syncPresent && lossCode == '0) |=> syncPresent);

  assert_instant_acquire_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!syncPresent && lineStrobe && syncHit && acqCode == '0) |=> syncPresent);

  assert_rise_cause_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(syncPresent) |-> $past(lineStrobe && syncHit));

  assert_fall_cause_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(syncPresent) |-> $past(lineStrobe && !syncHit));
endmodule

bind sync_presence_detector spd_checker #(.ACQ_W(ACQ_W), .LOSS_W(LOSS_W)) chk_i (
  .clk(clk), .rstN(rstN), .lineStrobe(lineStrobe), .syncHit(syncHit),
  .acqCode(acqCode), .lossCode(lossCode), .syncPresent(syncPresent));

// File: tb/sync_presence_detector_tb_top.sv
module sync_presence_detector_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       lineStrobe = 1'b0;
  logic       syncHit = 1'b0;
  logic [2:0] acqCode = 3'b000;
  logic [3:0] lossCode = 4'b0000;
  logic       syncPresent;

  int vecCnt = 0;
  int errCnt = 0;
  int refRun = 0;
  bit refPresent = 1'b0;

  always #10 clk = ~clk;

  sync_presence_detector dut_i (
    .clk(clk), .rstN(rstN), .lineStrobe(lineStrobe), .syncHit(syncHit),
    .acqCode(acqCode), .lossCode(lossCode), .syncPresent(syncPresent));

  function automatic int acqLen(logic [2:0] c);
    case (c)
      3'b000: return 0;
      3'b001: return 4;
      3'b010: return 8;
      3'b100: return 16;
      default: return 16;   // R8
    endcase
  endfunction

  function automatic int lossLen(logic [3:0] c);
    case (c)
      4'b0000: return 0;    // never
      4'b0001: return 32;
      4'b0010: return 64;
      4'b0100: return 128;
      4'b1000: return 256;
      default: return 256;  // R8
    endcase
  endfunction

  task automatic check(bit exp, string tag);
    vecCnt++;
    if (syncPresent !== exp) begin
      errCnt++;
      $display("FAIL %s: syncPresent=%0b expected %0b at %0t", tag, syncPresent, exp, $time);
    end
  endtask

  // One cycle: drive at negedge, model the edge, check at next negedge
  task automatic step(bit stb, bit hit, string tag);
    lineStrobe = stb;
    syncHit    = hit;
    @(posedge clk);
    if (stb) begin
      if (!refPresent) begin
        if (hit) begin
          refRun++;
          if (refRun >= acqLen(acqCode)) begin refPresent = 1'b1; refRun = 0; end
        end else refRun = 0;
      end else begin
        if (!hit && lossLen(lossCode) != 0) begin
          refRun++;
          if (refRun >= lossLen(lossCode)) begin refPresent = 1'b0; refRun = 0; end
        end else refRun = 0;
      end
    end
    @(negedge clk);
    check(refPresent, tag);
  endtask

  task automatic doReset();
    rstN = 1'b0; lineStrobe = 1'b0; syncHit = 1'b0;
    refPresent = 1'b0; refRun = 0;
    repeat (2) @(negedge clk);
    check(1'b0, "R1 in reset");
    rstN = 1'b1;
    @(negedge clk);
    check(1'b0, "R1 after reset");
  endtask

  task automatic run(int n, bit hit, string tag);
    for (int i = 0; i < n; i++) step(1'b1, hit, tag);
  endtask

  initial begin
    #(20 * 200000);
    errCnt++;
    $display("FAIL watchdog: run expected to end, still active");
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    @(negedge clk);
    doReset();

    // R2: code 0 acquires on first hit
    acqCode = 3'b000; lossCode = 4'b0001;
    step(1'b1, 1'b1, "R2");
    check(1'b1, "R2 literal");

    // R5: 31 misses keep, 32nd drops
    run(31, 1'b0, "R5 short");
    check(1'b1, "R5 before 32");
    // R7: hit clears miss run
    step(1'b1, 1'b1, "R7");
    run(31, 1'b0, "R7 restart");
    check(1'b1, "R7 still present");
    step(1'b1, 1'b0, "R5 32nd");
    check(1'b0, "R5 literal drop");

    // R3: code 001 needs 4
    acqCode = 3'b001;
    run(3, 1'b1, "R3 four");
    check(1'b0, "R3 before 4");
    // R9: ignored hit without strobe
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, "R9");
    // R4: miss clears hit run
    step(1'b1, 1'b0, "R4");
    run(3, 1'b1, "R4 restart");
    check(1'b0, "R4 literal");
    step(1'b1, 1'b1, "R3 fourth");
    check(1'b1, "R3 literal 4");

    // R6: never lose
    lossCode = 4'b0000;
    run(300, 1'b0, "R6");
    check(1'b1, "R6 literal");

    // R8: unlisted loss code -> 256
    lossCode = 4'b0011;
    run(255, 1'b0, "R8 loss");
    check(1'b1, "R8 loss 255");
    step(1'b1, 1'b0, "R8 loss 256");
    check(1'b0, "R8 loss literal");

    // R8: unlisted acquire code -> 16; R3 code 010 -> 8; code 100 -> 16
    acqCode = 3'b011;
    run(15, 1'b1, "R8 acq");
    check(1'b0, "R8 acq 15");
    step(1'b1, 1'b1, "R8 acq 16");
    check(1'b1, "R8 acq literal");
    lossCode = 4'b0010;
    run(64, 1'b0, "R5 64");
    check(1'b0, "R5 64 literal");
    acqCode = 3'b010;
    run(8, 1'b1, "R3 eight");
    lossCode = 4'b0100;
    run(128, 1'b0, "R5 128");
    acqCode = 3'b100;
    run(16, 1'b1, "R3 sixteen");
    lossCode = 4'b1000;
    run(256, 1'b0, "R5 256");

    // R1: reset mid-run
    run(3, 1'b1, "R1 prep");
    doReset();

    // Random bursts: R3 R5 R7 R9 R10
    for (int b = 0; b < 60; b++) begin
      int pHit;
      pHit = ($urandom_range(0, 1) == 1) ? 97 : 2;
      if ($urandom_range(0, 3) == 0) acqCode = 3'($urandom_range(0, 7));
      else acqCode = 3'(1 << $urandom_range(0, 2));
      if ($urandom_range(0, 3) == 0) lossCode = 4'($urandom_range(0, 15));
      else lossCode = 4'(1 << $urandom_range(0, 3));
      for (int i = 0; i < 300; i++) begin
        step(($urandom_range(0, 9) != 0), ($urandom_range(0, 99) < pHit), "R10 random");
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end
endmodule